// File: doc/BRIEF.md
# Shared Prescaler and Divider Tick Generator

This block turns one input clock into a set of count-enable strobes, one per timer channel. Two 8-bit prescalers run off the input clock. The low prescaler serves the first pair of channels and the high prescaler serves every channel above them. Each channel then passes its prescaler's output pulses through its own power-of-two divider, chosen by a 4-bit log2-coded select field. The strobe a channel counter receives has a rate equal to the input clock divided by the prescaler ratio times the divider ratio.

Configuration arrives as two static words. The first word packs both prescaler values. The second packs one select field per channel. A new prescaler value is taken up only when that prescaler wraps. A new divider select is taken up only when that channel's divider wraps, so a change in the middle of a period never shortens that period. The block only makes clock enables. It never derives a clock.

Top module: `tick_enable_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `tick_o` is 0. This holds even when the configuration would otherwise tick on every cycle.
- R2: A prescaler field value N divides by N+1. Bits 7:0 of `psc_cfg_i` serve channels 0 and 1. Bits 15:8 serve channels 2 and above.
- R3: Channel n takes its divider select from bits 4n+3:4n of `div_cfg_i`. The divider ratio is 2^(code + DIV_BASE).
- R4: With DIV_BASE=1, select code 0 divides by 2 and code 3 divides by 16. With DIV_BASE=0, code 0 divides by 1.
- R5: Any select code whose ratio would exceed 16 saturates to divide-by-16. Examples are code 9 or 15 with DIV_BASE=0, and code 7 with DIV_BASE=1.
- R6: In steady state, successive ticks on a channel are exactly (N+1) x 2^k input cycles apart. Each tick lasts one cycle when that product exceeds 1, and `tick_o` stays high on every cycle when the product is 1.
- R7: A prescaler field change takes effect at that prescaler's next wrap. The interval in progress completes at the old ratio, the following interval uses the new ratio, and no extra tick is produced.
- R8: A divider select change takes effect at that channel's next tick. The interval in progress completes at the old ratio, and the following interval uses the new ratio.
- R9: Channels that share a prescaler tick at independent rates, each set by its own select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all ticks are in this domain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc_cfg_i | input | 16 | Two prescaler fields (ratio minus one): low byte serves channels 0-1, high byte serves channels 2 and up |
| div_cfg_i | input | NUM_CH*4 | Per-channel log2 divider select, channel n at bits 4n+3:4n |
| tick_o | output | NUM_CH | One-cycle count-enable strobe per channel |

## Verification
Three configuration vectors cover the main function. The first sets every ratio to 1, so `tick_o` must stay high on every cycle. The second uses the 25x2 setting with different codes on channels that share a prescaler, which separates the low and high prescaler bytes and shows that the channels are independent. The third uses saturating codes together with a large high-byte prescaler, which exposes errors in field position or saturation. A second instance built with DIV_BASE=1 shows the shifted code base. Directed sequences change a prescaler and then a divider select in the middle of a period, and measure the interval across the change and the interval after it. These two measurements show whether a change is applied at the wrap or immediately.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned PSC_W    = 8;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned MAX_LOG2 = 4;
  localparam int unsigned DCNT_W   = MAX_LOG2;

  // select code -> divider terminal count (ratio - 1), saturating at 2^MAX_LOG2
  function automatic logic [DCNT_W-1:0] sel_to_limit(input logic [SEL_W-1:0] code,
                                                      input int unsigned base);
    int unsigned l2;
    l2 = int'(code) + base;
    if (l2 > MAX_LOG2) l2 = MAX_LOG2;
    return DCNT_W'((32'd1 << l2) - 32'd1);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] ratio_m1_i,
  output logic             pulse_o
);
  logic [PSC_W-1:0] cnt_q, lim_q;

  assign pulse_o = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (pulse_o) begin
      cnt_q <= '0;
      lim_q <= ratio_m1_i;  // new ratio only at wrap
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  assert_restart_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == '0));
  assert_limit_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |=> $stable(lim_q));
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter int unsigned DIV_BASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DCNT_W-1:0] dcnt_q, dlim_q;
  logic              hit;
  logic              tick_q;

  assign hit    = (dcnt_q == dlim_q);
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      dlim_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= pulse_i & hit;
      if (pulse_i) begin
        if (hit) begin
          dcnt_q <= '0;
          dlim_q <= sel_to_limit(sel_i, DIV_BASE);  // new select only at wrap
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  assert_dcnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q <= dlim_q);
  assert_limit_pow2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dlim_q + 1'b1) & dlim_q) == '0);
  assert_tick_follows_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(pulse_i));
  assert_limit_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_i && hit) |=> $stable(dlim_q));
endmodule

// File: rtl/tick_enable_gen.sv
module tick_enable_gen
  import tick_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned LO_CH    = 2,
  parameter int unsigned DIV_BASE = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2*PSC_W-1:0]        psc_cfg_i,
  input  logic [NUM_CH*SEL_W-1:0]   div_cfg_i,
  output logic [NUM_CH-1:0]         tick_o
);
  localparam int unsigned NUM_PSC = 2;

  logic [NUM_PSC-1:0] psc_pulse;

  for (genvar p = 0; p < NUM_PSC; p++) begin : g_psc
    tick_prescaler i_psc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ratio_m1_i(psc_cfg_i[p*PSC_W +: PSC_W]),
      .pulse_o   (psc_pulse[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < LO_CH) ? 0 : 1;
    tick_divider #(.DIV_BASE(DIV_BASE)) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(psc_pulse[GRP]),
      .sel_i  (div_cfg_i[c*SEL_W +: SEL_W]),
      .tick_o (tick_o[c])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (tick_o == '0));
endmodule

// File: tb/test_tick_enable_gen.sv
module test_tick_enable_gen;
  localparam int NCH = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     psc_a = '0, psc_b = '0;
  logic [NCH*4-1:0] div_a = '0, div_b = '0;
  logic [NCH-1:0]  tick_a, tick_b;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_enable_gen #(.NUM_CH(NCH), .DIV_BASE(0)) i_tick_enable_gen (
    .clk_i(clk), .rst_ni(rst_n), .psc_cfg_i(psc_a), .div_cfg_i(div_a), .tick_o(tick_a));
  tick_enable_gen #(.NUM_CH(NCH), .DIV_BASE(1)) i_tick_enable_gen_b1 (
    .clk_i(clk), .rst_ni(rst_n), .psc_cfg_i(psc_b), .div_cfg_i(div_b), .tick_o(tick_b));

  localparam logic [15:0] VPSC [3] = '{16'h0000, 16'h0118, 16'h0603};
  localparam logic [19:0] VDIV [3] = '{20'h00000, 20'h42001, 20'h01F93};
  localparam int VEXP [3][5] = '{'{1, 1, 1, 1, 1},
                                 '{50, 25, 2, 8, 32},
                                 '{32, 64, 112, 14, 7}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tk(input bit b, input int ch);
    return b ? tick_b[ch] : tick_a[ch];
  endfunction

  task automatic wait_tick(input bit b, input int ch);
    for (int n = 0; n < 2000 && !tk(b, ch); n++) @(negedge clk);
  endtask

  task automatic count_to_tick(input bit b, input int ch, output int iv);
    iv = 0;
    do begin
      @(negedge clk);
      iv++;
    end while (!tk(b, ch) && iv < 2000);
  endtask

  task automatic measure(input bit b, input int ch, output int iv);
    @(negedge clk);
    wait_tick(b, ch);
    count_to_tick(b, ch, iv);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int iv;
    // R1: all-ones ratio config held in reset must not tick
    repeat (5) @(negedge clk);
    chk("R1 tick_o in reset (base0)", int'(tick_a), 0);
    chk("R1 tick_o in reset (base1)", int'(tick_b), 0);
    rst_n = 1'b1;

    // vector table: R2 R3 R5 R6 R9
    for (int v = 0; v < 3; v++) begin
      psc_a = VPSC[v];
      div_a = VDIV[v];
      repeat (400) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        measure(1'b0, c, iv);
        chk($sformatf("R2/R3/R5/R9 vec%0d ch%0d period", v, c), iv, VEXP[v][c]);
      end
    end

    // R6: one-cycle strobe at ratio 50 on ch0
    psc_a = 16'h0118; div_a = 20'h42001;
    repeat (400) @(negedge clk);
    @(negedge clk);
    wait_tick(1'b0, 0);
    @(negedge clk);
    chk("R6 strobe width ch0", int'(tick_a[0]), 0);

    // R6: ratio 1 holds tick high
    psc_a = 16'h0000; div_a = 20'h00000;
    repeat (200) @(negedge clk);
    chk("R6 ratio1 all high", int'(tick_a), 5'h1f);

    // R4: shifted code base (codes ch0=0 ch1=2 ch2=3 ch3=7 ch4=1)
    psc_b = 16'h0000; div_b = 20'h17320;
    repeat (100) @(negedge clk);
    measure(1'b1, 0, iv); chk("R4 base1 code0 -> /2", iv, 2);
    measure(1'b1, 1, iv); chk("R4 base1 code2 -> /8", iv, 8);
    measure(1'b1, 2, iv); chk("R4 base1 code3 -> /16", iv, 16);
    measure(1'b1, 3, iv); chk("R5 base1 code7 saturates /16", iv, 16);
    measure(1'b1, 4, iv); chk("R4 base1 code1 -> /4", iv, 4);

    // R7: prescaler change mid-period
    psc_a = 16'h0009; div_a = 20'h00000;
    repeat (100) @(negedge clk);
    @(negedge clk);
    wait_tick(1'b0, 0);
    repeat (3) @(negedge clk);
    psc_a = 16'h0003;
    count_to_tick(1'b0, 0, iv);
    chk("R7 interval across psc change", iv + 3, 10);
    count_to_tick(1'b0, 0, iv);
    chk("R7 interval after psc change", iv, 4);

    // R8: divider change mid-period on ch1 (/16 -> /2), prescaler ratio 1
    psc_a = 16'h0000; div_a = 20'h00040;
    repeat (100) @(negedge clk);
    @(negedge clk);
    wait_tick(1'b0, 1);
    repeat (3) @(negedge clk);
    div_a = 20'h00010;
    count_to_tick(1'b0, 1, iv);
    chk("R8 interval across div change", iv + 3, 16);
    count_to_tick(1'b0, 1, iv);
    chk("R8 interval after div change", iv, 2);

    // R1: reset reasserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 tick_o after reset reassert", int'(tick_a), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule